// File: doc/BRIEF.md
# I2C Master Receive Engine

This block is the receive-direction half of an I2C bus master. On a start request it puts a START (or a repeated START if it already owns the bus) on the wire. It then shifts out a 7-bit slave address with the read bit set and clocks in data bytes, MSB first. Each byte is acknowledged by default. A one-shot NACK request or a stop request makes the master refuse a byte instead. A refused byte is followed either by a STOP or by a pause with SCL held low, during which a new start request chains a repeated START.

The engine does not pause after each byte. It keeps clocking the next byte into its shift register. Only when the single-entry holding buffer is still unread does it halt, just before the eighth bit of the new byte, with SCL held low. A byte counter, loadable only while the engine is held in soft reset, raises an early warning during the last expected byte. Software therefore has time to request the NACK. Both bus lines are open-drain: the block only outputs pull-low enables and reads back SDA.

Top module: `i2c_rx_master`

## Requirements
- R1: After rst_n low, or while soft_rst is high, both pull-low enables are 0, busy, rx_ready, start_pend, stop_pend, nack_pend, nack_rcvd and last_flag are 0, and the engine stays idle.
- R2: A start_req from idle produces a START (SDA falls while SCL is high), then the address bits slave_addr[6:0] MSB first, followed by a read bit of 1. start_pend stays high until the acknowledge slot of the address has been clocked, then clears by itself.
- R3: Data bits are taken MSB first, each sampled while SCL is high. A complete byte is placed on rx_data with rx_ready set to 1 whenever the buffer is empty. rd_strobe clears rx_ready, and an unread byte is never overwritten.
- R4: One divider tick lasts clk_div+1 clock cycles. SCL is low for two ticks and high for two ticks per bit (8 cycles high for clk_div=3), and SDA does not change while SCL is high inside a bit slot.
- R5: After a byte, the engine starts the next byte at once and drives ACK (SDA low) in the acknowledge slot unless a NACK or a stop is pending.
- R6: If rx_ready is still 1 when the eighth bit of a byte is due, the engine halts with SCL held low and stalled=1, and continues only after rd_strobe.
- R7: nack_req makes the master send NACK (SDA released) in the acknowledge slot of the byte in progress. nack_pend then clears by itself, and the engine keeps SCL low with busy=1 until a start or stop request.
- R8: A start_req while the engine holds the bus produces a repeated START with no STOP before it.
- R9: stop_req makes the master NACK the byte in progress and then send a STOP (SDA rising while SCL is high). If the engine is halted on a full buffer, it proceeds at once: it drops the partial byte, keeps the unread one, and sends the NACK and the STOP.
- R10: If the address is not acknowledged, nack_rcvd goes to 1 and the engine sends a STOP and returns to idle with start_pend 0.
- R11: cnt_wr loads cnt_value into the byte counter only while soft_rst is high. With a nonzero count, last_flag goes to 1 when the third bit of the byte for which one byte remains has been sampled. A count of 0 disables the flag.
- R12: stop_req and nack_req are ignored while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Holds the engine idle; enables byte-counter writes |
| clk_div | input | DIV_W | Divider: one tick per clk_div+1 cycles |
| slave_addr | input | 7 | Target address |
| start_req | input | 1 | Request START or repeated START |
| stop_req | input | 1 | Request NACK then STOP |
| nack_req | input | 1 | Request NACK for the byte in progress |
| rd_strobe | input | 1 | Software has taken rx_data |
| cnt_wr | input | 1 | Byte-counter write strobe |
| cnt_value | input | CNT_W | Byte-counter load value |
| start_pend | output | 1 | Start request not yet completed |
| stop_pend | output | 1 | Stop request not yet completed |
| nack_pend | output | 1 | NACK request not yet sent |
| busy | output | 1 | Engine owns the bus |
| stalled | output | 1 | SCL held low waiting for a buffer read |
| rx_data | output | 8 | Receive holding buffer |
| rx_ready | output | 1 | Holding buffer full |
| nack_rcvd | output | 1 | Address was not acknowledged |
| last_flag | output | 1 | Final counted byte has reached its third bit |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
A bus-level slave model answers the address and serves bytes, and a scoreboard compares every buffered byte with the one the slave sent. The bench leaves the buffer unread to force the stall: a design that overwrote the buffer, or kept clocking, would lose a byte or let SCL rise. Several other cases are also driven: a stop issued during the stall, a one-shot NACK followed by a repeated START, an unacknowledged address, and requests made while idle. A wrong implementation would show as a missing or extra STOP, an ACK where a NACK belongs, a request bit left set, or a corrupted buffer. The counter is loaded once inside soft reset and once outside it. A design that accepted the second write would raise last_flag on the wrong byte or never.

// File: rtl/i2c_rx_pkg.sv
// Shared types for the I2C master receive engine.
// Assumes: a single clock domain; all states are used by i2c_rx_master only.
package i2c_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_DATA,
        ST_ACK,
        ST_HOLD,
        ST_STOP
    } eng_state_t;

endpackage

// File: rtl/i2c_rx_tickgen.sv
// Bus-timing divider: emits a one-cycle tick every clk_div+1 cycles.
// Assumes: clk_div is held steady while a transfer runs; clr restarts the count.
module i2c_rx_tickgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Tick whenever the count has reached the programmed limit.
    assign tick = !clr && (cnt >= div);

    // Count up to the limit, then wrap; clear holds it at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (cnt >= div)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // With a nonzero divider two ticks are never back to back (R4).
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || !$stable(div)));

endmodule

// File: rtl/i2c_rx_bytecnt.sv
// Remaining-byte counter used to warn software ahead of the final byte.
// Assumes: load is only asserted by the parent while the engine is in soft reset.
module i2c_rx_bytecnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    input  logic             dec,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    // Exactly one byte left: the byte now being clocked is the final one.
    assign last = (remain == ONE);

    // Load a new count or step down once per completed byte, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= value;
        else if (dec && remain != '0)
            remain <= remain - ONE;
    end

endmodule

// File: rtl/i2c_rx_master.sv
// I2C master receive engine: START/repeated START, 7-bit read address,
// byte reception with ACK/NACK, STOP, single-entry buffer with bus stall.
// Assumes: sda_in is already synchronous to clk; no clock stretching,
// no arbitration; each bit slot is four divider ticks (two low, two high).
module i2c_rx_master
    import i2c_rx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [6:0]       slave_addr,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             nack_req,
    input  logic             rd_strobe,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_value,
    output logic             start_pend,
    output logic             stop_pend,
    output logic             nack_pend,
    output logic             busy,
    output logic             stalled,
    output logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             nack_rcvd,
    output logic             last_flag,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);

    localparam logic [3:0] ACK_BIT  = 4'd8;
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] WARN_BIT = 4'd2;

    eng_state_t st;
    logic [1:0] ph;
    logic [3:0] bitn;
    logic [7:0] shreg;
    logic       send_nack;
    logic       ack_ok;
    logic       from_hold;
    logic       sda_q;
    logic       scl_d;
    logic       sda_d;
    logic       tick;
    logic       cnt_last;
    logic       stall_cond;
    logic       adv;
    logic       slot_end;
    logic       sample;
    logic       byte_done;
    logic [7:0] addr_byte;

    i2c_rx_tickgen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (soft_rst || st == ST_IDLE),
        .div  (clk_div),
        .tick (tick)
    );

    i2c_rx_bytecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cnt_wr && soft_rst),
        .value(cnt_value),
        .dec  (byte_done),
        .last (cnt_last)
    );

    // Slot bookkeeping: stall point, phase advance, sample point, byte end.
    assign addr_byte  = {slave_addr, 1'b1};
    assign stall_cond = (st == ST_DATA) && (bitn == LAST_BIT) && (ph == 2'd0)
                        && rx_ready && !stop_pend;
    assign adv        = tick && !stall_cond;
    assign slot_end   = adv && (ph == 2'd3);
    assign sample     = adv && (ph == 2'd2);
    assign byte_done  = (st == ST_DATA) && (bitn == LAST_BIT) && slot_end;
    assign busy       = (st != ST_IDLE);
    assign stalled    = stall_cond;
    assign scl_oe     = scl_d;
    assign sda_oe     = sda_q;

    // Line drive per state and phase; SDA is registered so it trails SCL edges.
    always_comb begin
        scl_d = 1'b0;
        sda_d = 1'b0;
        case (st)
            ST_START: begin
                scl_d = (ph == 2'd0) ? from_hold : (ph == 2'd3);
                sda_d = (ph >= 2'd2);
            end
            ST_ADDR: begin
                scl_d = (ph < 2'd2);
                sda_d = (bitn < ACK_BIT) ? !addr_byte[3'd7 - bitn[2:0]] : 1'b0;
            end
            ST_DATA: scl_d = (ph < 2'd2);
            ST_ACK: begin
                scl_d = (ph < 2'd2);
                sda_d = !send_nack;
            end
            ST_HOLD: scl_d = 1'b1;
            ST_STOP: begin
                scl_d = (ph < 2'd2);
                sda_d = (ph != 2'd3);
            end
            default: ;
        endcase
    end

    // SDA output register, one cycle behind the state that requests it.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            sda_q <= 1'b0;
        else
            sda_q <= sda_d;
    end

    // Sequencer: walks phases and bit slots and picks the next bus action.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            st        <= ST_IDLE;
            ph        <= 2'd0;
            bitn      <= 4'd0;
            from_hold <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_pend) begin
                        st        <= ST_START;
                        ph        <= 2'd0;
                        from_hold <= 1'b0;
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        if (start_pend) begin
                            st        <= ST_START;
                            ph        <= 2'd0;
                            from_hold <= 1'b1;
                        end else if (stop_pend) begin
                            st <= ST_STOP;
                            ph <= 2'd0;
                        end
                    end
                end
                default: begin
                    if (adv)
                        ph <= ph + 2'd1;
                    if (slot_end) begin
                        case (st)
                            ST_START: begin
                                st   <= ST_ADDR;
                                bitn <= 4'd0;
                            end
                            ST_ADDR: begin
                                if (bitn == ACK_BIT) begin
                                    bitn <= 4'd0;
                                    st   <= ack_ok ? ST_DATA : ST_STOP;
                                end else begin
                                    bitn <= bitn + 4'd1;
                                end
                            end
                            ST_DATA: begin
                                if (bitn == LAST_BIT)
                                    st <= ST_ACK;
                                else
                                    bitn <= bitn + 4'd1;
                            end
                            ST_ACK: begin
                                bitn <= 4'd0;
                                if (!send_nack)
                                    st <= ST_DATA;
                                else if (stop_pend)
                                    st <= ST_STOP;
                                else
                                    st <= ST_HOLD;
                            end
                            ST_STOP: st <= ST_IDLE;
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    // Request bits, sampling, holding buffer and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            start_pend <= 1'b0;
            stop_pend  <= 1'b0;
            nack_pend  <= 1'b0;
            nack_rcvd  <= 1'b0;
            last_flag  <= 1'b0;
            rx_ready   <= 1'b0;
            rx_data    <= 8'h00;
            shreg      <= 8'h00;
            send_nack  <= 1'b0;
            ack_ok     <= 1'b0;
        end else begin
            if (rd_strobe)
                rx_ready <= 1'b0;
            if (start_req) begin
                start_pend <= 1'b1;
                nack_rcvd  <= 1'b0;
                last_flag  <= 1'b0;
            end
            if (stop_req && busy)
                stop_pend <= 1'b1;
            if (nack_req && busy)
                nack_pend <= 1'b1;
            if (sample && st == ST_ADDR && bitn == ACK_BIT)
                ack_ok <= !sda_in;
            if (sample && st == ST_DATA) begin
                shreg <= {shreg[6:0], sda_in};
                if (bitn == WARN_BIT && cnt_last)
                    last_flag <= 1'b1;
            end
            if (byte_done) begin
                send_nack <= nack_pend || stop_pend;
                if (!rx_ready) begin
                    rx_data  <= shreg;
                    rx_ready <= 1'b1;
                end
            end
            if (st == ST_ADDR && bitn == ACK_BIT && slot_end) begin
                start_pend <= 1'b0;
                if (!ack_ok)
                    nack_rcvd <= 1'b1;
            end
            if (st == ST_ACK && slot_end && send_nack)
                nack_pend <= 1'b0;
            if (st == ST_STOP && slot_end)
                stop_pend <= 1'b0;
        end
    end

    // While the engine waits on the buffer, SCL must stay pulled low (R6).
    assert_stall_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> scl_oe);

    // An unread byte is neither dropped nor replaced (R3).
    assert_buffer_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_strobe && !soft_rst) |=> (rx_ready && $stable(rx_data)));

    // Inside a bit slot SDA holds while SCL is released (R4).
    assert_sda_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && $past(st) == st &&
         (st == ST_ADDR || st == ST_DATA || st == ST_ACK)) |-> $stable(sda_oe));

    // The NACK request clears only at the end of an acknowledge slot (R7).
    assert_nack_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(nack_pend) && !$past(soft_rst)) |-> ($past(st) == ST_ACK));

    // The start request clears only once the address slot has ended (R2).
    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(start_pend) && !$past(soft_rst)) |-> ($past(st) == ST_ADDR));

    // An idle engine leaves SDA released once the last STOP has finished (R1).
    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !sda_oe);

endmodule

// File: tb/tb_i2c_rx_master.sv
// Scoreboard bench: a bus-level slave serves bytes, the driver queues the
// bytes that should reach the buffer, and a monitor pops and compares them.
module tb_i2c_rx_master;

    localparam int DIV_W = 8;
    localparam int CNT_W = 8;
    localparam logic [6:0] SLV_ADDR = 7'h2D;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             soft_rst = 1'b0;
    logic [DIV_W-1:0] clk_div = 8'd3;
    logic [6:0]       slave_addr = SLV_ADDR;
    logic             start_req = 1'b0;
    logic             stop_req = 1'b0;
    logic             nack_req = 1'b0;
    logic             rd = 1'b0;
    logic             cnt_wr = 1'b0;
    logic [CNT_W-1:0] cnt_value = '0;
    logic start_pend, stop_pend, nack_pend, busy, stalled, rx_ready, nack_rcvd, last_flag;
    logic [7:0] rx_data;
    logic scl_oe, sda_oe;
    logic slv_drv = 1'b0;
    logic scl_line, sda_line;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slv_drv);

    i2c_rx_master #(.DIV_W(DIV_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clk_div(clk_div),
        .slave_addr(slave_addr), .start_req(start_req), .stop_req(stop_req),
        .nack_req(nack_req), .rd_strobe(rd), .cnt_wr(cnt_wr), .cnt_value(cnt_value),
        .start_pend(start_pend), .stop_pend(stop_pend), .nack_pend(nack_pend),
        .busy(busy), .stalled(stalled), .rx_data(rx_data), .rx_ready(rx_ready),
        .nack_rcvd(nack_rcvd), .last_flag(last_flag), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    logic [7:0] src_q[$];
    int  popped = 0;
    logic auto_read = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Slave model state
    int mode = 0;
    int n = 0;
    int m = 0;
    int starts = 0;
    int stops = 0;
    int hi_cnt = 0;
    int hi_len = 0;
    int mack_cnt = 0;
    logic [7:0] ashift = 8'h00;
    logic [7:0] seen_addr = 8'h00;
    logic [7:0] cur = 8'h00;
    logic acked = 1'b0;
    logic last_mack = 1'b0;
    logic ps = 1'b1;
    logic psda = 1'b1;
    logic s_scl, s_sda;

    function automatic logic [7:0] next_src();
        if (src_q.size() == 0) return 8'hFF;
        return src_q.pop_front();
    endfunction

    // Slave: detects START/STOP, acknowledges its address, serves data bytes.
    always @(negedge clk) begin
        s_scl = scl_line;
        s_sda = sda_line;
        if (!ps && s_scl) hi_cnt = 1;
        else if (s_scl) hi_cnt = hi_cnt + 1;
        if (ps && s_scl && psda && !s_sda) begin
            mode = 1; n = 0; slv_drv = 1'b0; starts++;
        end else if (ps && s_scl && !psda && s_sda) begin
            mode = 0; slv_drv = 1'b0; stops++;
        end else if (!ps && s_scl) begin
            if (mode == 1 && n >= 1 && n <= 8) ashift = {ashift[6:0], s_sda};
            if (mode == 2 && m == 8) begin last_mack = s_sda; mack_cnt++; end
        end else if (ps && !s_scl) begin
            if (mode == 2) hi_len = hi_cnt;
            if (mode == 1) begin
                n++;
                if (n == 9) begin
                    seen_addr = ashift;
                    acked = (ashift == {SLV_ADDR, 1'b1});
                    slv_drv = acked;
                end else if (n == 10) begin
                    slv_drv = 1'b0;
                    if (acked) begin
                        mode = 2; m = 0; cur = next_src(); slv_drv = !cur[7];
                    end else mode = 0;
                end
            end else if (mode == 2) begin
                m++;
                if (m < 8) slv_drv = !cur[7-m];
                else if (m == 8) slv_drv = 1'b0;
                else if (!last_mack) begin
                    m = 0; cur = next_src(); slv_drv = !cur[7];
                end else begin
                    mode = 0; slv_drv = 1'b0;
                end
            end
        end
        ps = s_scl;
        psda = s_sda;
    end

    // Monitor: pops the expected byte and compares whenever the buffer fills.
    always @(negedge clk) begin
        if (rd) rd = 1'b0;
        else if (rx_ready && auto_read && rst_n) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3 unexpected byte actual=%0h expected=none", rx_data);
            end else begin
                chk("R3 scoreboard byte", rx_data, exp_q.pop_front());
            end
            popped++;
            rd = 1'b1;
        end
    end

    task automatic push(input logic [7:0] v, input bit deliver);
        src_q.push_back(v);
        if (deliver) exp_q.push_back(v);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_req = 1'b1;
        @(negedge clk) stop_req = 1'b0;
    endtask

    task automatic pulse_nack();
        @(negedge clk) nack_req = 1'b1;
        @(negedge clk) nack_req = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    int s0, p0, t0, f_at;

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 scl_oe after reset", scl_oe, 0);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 busy/ready/flags after reset",
            {busy, rx_ready, start_pend, stop_pend, nack_pend, nack_rcvd, last_flag}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // T1: three bytes, stop after the second is buffered
        auto_read = 1'b1;
        push(8'hA5, 1); push(8'h3C, 1); push(8'hF0, 1);
        s0 = stops; t0 = mack_cnt;
        pulse_start();
        chk("R2 start_pend set by request", start_pend, 1);
        wait (start_pend == 1'b0);
        chk("R2 address byte with read bit", seen_addr, {SLV_ADDR, 1'b1});
        chk("R2 slave saw one START", starts, 1);
        wait (exp_q.size() == 1);
        pulse_stop();
        wait_idle();
        chk("R9 stop issued", stops, s0 + 1);
        chk("R5 acks then nack count", mack_cnt - t0, 3);
        chk("R9 final byte refused", last_mack, 1);
        chk("R9 stop_pend cleared", stop_pend, 0);
        chk("R3 all bytes delivered", exp_q.size(), 0);
        chk("R4 scl high length cycles", hi_len, 8);

        // T2: stall with the buffer left unread
        auto_read = 1'b0;
        src_q.delete();
        push(8'h11, 1); push(8'h22, 1); push(8'h33, 0);
        t0 = mack_cnt;
        pulse_start();
        wait (stalled == 1'b1);
        chk("R6 first byte buffered", rx_data, 8'h11);
        repeat (200) @(negedge clk);
        chk("R6 still stalled without read", stalled, 1);
        chk("R6 scl held low", scl_line, 0);
        auto_read = 1'b1;
        wait (stalled == 1'b0);
        pulse_stop();
        wait_idle();
        chk("R5 first byte acked then second refused", mack_cnt - t0, 2);
        chk("R6 resumed and delivered", exp_q.size(), 0);

        // T3: stop while stalled drops the partial byte
        auto_read = 1'b0;
        src_q.delete();
        push(8'h44, 0); push(8'h55, 0);
        s0 = stops;
        pulse_start();
        wait (stalled == 1'b1);
        pulse_stop();
        wait_idle();
        chk("R9 stop during stall issued", stops, s0 + 1);
        chk("R9 partial byte refused", last_mack, 1);
        chk("R9 old byte kept", rx_data, 8'h44);
        chk("R9 buffer still full", rx_ready, 1);
        exp_q.push_back(8'h44);
        auto_read = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9 no extra byte after read", rx_ready, 0);
        chk("R9 scoreboard drained", exp_q.size(), 0);

        // T4: one-shot nack, hold, repeated start
        src_q.delete();
        push(8'h66, 1); push(8'h77, 1); push(8'h88, 1);
        p0 = popped;
        pulse_start();
        wait (popped == p0 + 1);
        pulse_nack();
        wait (nack_pend == 1'b0);
        repeat (40) @(negedge clk);
        chk("R7 nack sent", last_mack, 1);
        chk("R7 nack_pend cleared", nack_pend, 0);
        chk("R7 bus held busy", busy, 1);
        chk("R7 scl held low", scl_line, 0);
        s0 = stops; t0 = starts;
        pulse_start();
        wait (start_pend == 1'b0);
        chk("R8 repeated start seen", starts, t0 + 1);
        chk("R8 no stop before restart", stops, s0);
        pulse_stop();
        wait_idle();
        chk("R8 session ended with stop", stops, s0 + 1);
        chk("R8 scoreboard drained", exp_q.size(), 0);

        // T5: address not acknowledged
        src_q.delete();
        slave_addr = 7'h2C;
        s0 = stops;
        pulse_start();
        wait_idle();
        chk("R10 nack_rcvd set", nack_rcvd, 1);
        chk("R10 stop after address nack", stops, s0 + 1);
        chk("R10 start_pend cleared", start_pend, 0);
        chk("R10 no byte buffered", rx_ready, 0);
        slave_addr = SLV_ADDR;

        // T6: requests while idle are ignored
        pulse_stop();
        pulse_nack();
        repeat (5) @(negedge clk);
        chk("R12 stop ignored idle", stop_pend, 0);
        chk("R12 nack ignored idle", nack_pend, 0);
        chk("R12 still idle", busy, 0);

        // T7: byte counter written in and out of soft reset
        @(negedge clk) soft_rst = 1'b1;
        cnt_value = 8'd2;
        @(negedge clk) cnt_wr = 1'b1;
        @(negedge clk) cnt_wr = 1'b0;
        chk("R1 soft reset clears nack_rcvd", nack_rcvd, 0);
        chk("R1 soft reset releases lines", {scl_oe, sda_oe}, 0);
        @(negedge clk) soft_rst = 1'b0;
        cnt_value = 8'd7;
        @(negedge clk) cnt_wr = 1'b1;
        @(negedge clk) cnt_wr = 1'b0;
        src_q.delete();
        push(8'hB1, 1); push(8'hB2, 1);
        p0 = popped;
        f_at = -1;
        pulse_start();
        for (int i = 0; i < 4000 && f_at < 0; i++) begin
            @(negedge clk);
            if (last_flag) f_at = popped - p0;
        end
        chk("R11 flag during final counted byte", f_at, 1);
        pulse_stop();
        wait_idle();
        chk("R11 final byte refused", last_mack, 1);
        chk("R11 scoreboard drained", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule